// File: doc/BRIEF.md
# Register-Mapped Asynchronous Serial Core

This block is one full-duplex asynchronous serial channel. Software controls it through seven word registers. An external baud generator supplies `baud_tick`, a one-cycle pulse at sixteen times the bit rate, and every bit on the line lasts sixteen of those pulses. The frame has 7, 8 or 9 data bits, sent least significant bit first. It can carry an optional even or odd parity bit and ends with one or two stop bits. The transmitter has a one-character holding register in front of its shifter. It can be held back by a clear-to-send input, and it can force a break onto the line.

The receiver brings the serial input through a two-flop synchronizer. It samples each bit once, in the middle of the bit. It rejects short start pulses, checks parity, and recognises a break. A break shows as a live level flag and as a sticky change flag. The sticky flags are cleared by writing a one to them. The single `irq` output combines receive-ready and transmit-ready, each gated by its own enable bit.

Register offsets on `reg_addr`:

| Offset | Register |
|---|---|
| 0 | configuration |
| 1 | control |
| 2 | status |
| 3 | interrupt-enable set (reads back the enables) |
| 4 | interrupt-enable clear |
| 5 | transmit data |
| 6 | receive data |

Top module: `usart_core`

## Requirements
- R1: After reset, `ser_tx` is 1 and `irq` is 0. The configuration register (offset 0) and the enable register (offset 3) read 0. The status register (offset 2) reads 0x0004, meaning only the transmit-ready bit (bit 2) is set.
- R2: While configuration bit 0 is 0, `ser_tx` stays at 1 and nothing is transmitted. A character written to transmit data (offset 5) waits, and its frame goes out once bit 0 is set.
- R3: A frame begins with a low start bit. The data bits follow, least significant first, then the stop bits, which are high. Each bit lasts 16 `baud_tick` pulses. Configuration bits 3:2 set the data length: 0 gives 7 bits, 1 gives 8, 2 gives 9, and 3 acts as 8. Configuration bit 6 selects two stop bits when it is 1 and one when it is 0.
- R4: Configuration bits 5:4 select parity: 2 is even, 3 is odd, and 0 or 1 means no parity. When parity is on, a parity bit follows the data bits, making the count of ones even or odd as selected. Receive data (offset 6) returns the data in bits 8:0. Bit 15 of that register is 1 when the character's parity bit was wrong.
- R5: While configuration bit 9 is 1, a frame does not start until `cts_in` is 1.
- R6: Status bit 0 sets when a character has been received. Reading offset 6 clears it. Writing offset 5 clears status bit 2 until the character is moved into the shifter.
- R7: Status bit 5 sets on every change of the synchronized `cts_in`. It stays set until a write to offset 2 with bit 5 at 1.
- R8: While the core is enabled and control bit 1 (offset 1) is 1, `ser_tx` is 0.
- R9: A frame whose data, parity and stop bits are all low sets status bit 10. Bit 10 stays set until the line returns high. Such a frame does not set status bit 0. Status bit 11 sets on each change of bit 10 and clears when 1 is written to it at offset 2.
- R10: The receiver samples each bit on the 8th tick of 16. A start bit that is high again at that point is dropped, and no character results.
- R11: Writing ones to offset 3 sets the enables and writing ones to offset 4 clears them. Enable bit 0 is for receive-ready and bit 2 is for transmit-ready. `irq` is 1 exactly when an enabled ready flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| baud_tick | input | 1 | One-cycle pulse at 16x the bit rate |
| reg_addr | input | 3 | Register offset |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe (side effects only) |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for `reg_addr`, combinational |
| ser_rx | input | 1 | Serial receive line |
| ser_tx | output | 1 | Serial transmit line |
| cts_in | input | 1 | Clear to send, 1 allows a frame to start |
| irq | output | 1 | Combined interrupt request |

## Verification
The main framing path is driven in loopback with random data under random settings of length, parity and stop count, including the reserved parity code. Each frame is compared bit by bit on `ser_tx` and again at the receive register. This separates mistakes in bit order and frame length from mistakes in parity polarity. Hand-built frames on `ser_rx` then probe the receiver alone. A frame with deliberately wrong parity must raise the error bit, and the same frame with correct parity must not. A short low pulse must be rejected as a false start, while a long all-zero stretch must be reported as a break rather than as data. Directed sequences around clear-to-send, the break control and the interrupt enables check gating and sticky clearing at the exact points where those flags change.

// File: rtl/usart_pkg.sv
package usart_pkg;

   localparam int MAX_DATA  = 9;
   localparam int MAX_FRAME = 13;   // start + 9 data + parity + 2 stop

   typedef enum logic [2:0] {
      A_CFG   = 3'd0,
      A_CTRL  = 3'd1,
      A_STAT  = 3'd2,
      A_IESET = 3'd3,
      A_IECLR = 3'd4,
      A_TXD   = 3'd5,
      A_RXD   = 3'd6
   } reg_addr_e;

   typedef struct packed {
      logic [3:0] nbits;
      logic       par_en;
      logic       par_odd;
      logic       two_stop;
   } frame_cfg_t;

   function automatic frame_cfg_t fmt_decode(input logic [15:0] c);
      frame_cfg_t f;
      f.nbits    = (c[3:2] == 2'd0) ? 4'd7 : (c[3:2] == 2'd2) ? 4'd9 : 4'd8;
      f.par_en   = c[5];
      f.par_odd  = c[4];
      f.two_stop = c[6];
      return f;
   endfunction

endpackage

// File: rtl/usart_sync.sv
module usart_sync #(
   parameter int             STAGES  = 2,
   parameter int             W       = 1,
   parameter logic [W-1:0]   RST_VAL = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] stg [STAGES];

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)      stg[g] <= RST_VAL;
         else if (g == 0) stg[g] <= d;
         else             stg[g] <= stg[(g == 0) ? 0 : g - 1];
      end
   end

   assign q = stg[STAGES-1];
endmodule

// File: rtl/usart_tx.sv
module usart_tx
   import usart_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                tick,
   input  frame_cfg_t          fmt,
   input  logic                brk,
   input  logic                cts_ok,
   input  logic                load_req,
   input  logic [MAX_DATA-1:0] data,
   output logic                load,
   output logic                txd
);
   localparam int CW = $clog2(OVS);
   localparam int FW = MAX_FRAME;
   localparam int BW = $clog2(FW + 1);

   logic          busy;
   logic [FW-1:0] shreg, nxt;
   logic [BW-1:0] bits_left, flen;
   logic [CW-1:0] tcnt;
   logic          par_bit;

   always_comb begin
      nxt     = '1;
      nxt[0]  = 1'b0;
      par_bit = fmt.par_odd;
      for (int i = 0; i < MAX_DATA; i++) begin
         if (i < int'(fmt.nbits)) begin
            nxt[i+1] = data[i];
            par_bit  = par_bit ^ data[i];
         end
      end
      for (int i = 0; i < FW; i++)
         if (fmt.par_en && i == int'(fmt.nbits) + 1) nxt[i] = par_bit;
      flen = BW'(fmt.nbits) + BW'(2) + BW'(fmt.par_en) + BW'(fmt.two_stop);
   end

   assign load = en && !busy && load_req && cts_ok;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy      <= 1'b0;
         shreg     <= '1;
         bits_left <= '0;
         tcnt      <= '0;
      end else if (!en) begin
         busy <= 1'b0;
         tcnt <= '0;
      end else if (load) begin
         busy      <= 1'b1;
         shreg     <= nxt;
         bits_left <= flen;
         tcnt      <= '0;
      end else if (busy && tick) begin
         if (tcnt == CW'(OVS - 1)) begin
            tcnt      <= '0;
            shreg     <= {1'b1, shreg[FW-1:1]};
            bits_left <= bits_left - 1'b1;
            if (bits_left == BW'(1)) busy <= 1'b0;
         end else begin
            tcnt <= tcnt + 1'b1;
         end
      end
   end

   assign txd = !en ? 1'b1 : brk ? 1'b0 : busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/usart_rx.sv
module usart_rx
   import usart_pkg::*;
#(
   parameter int OVS = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                en,
   input  logic                tick,
   input  frame_cfg_t          fmt,
   input  logic                rxd,
   output logic                valid,
   output logic [MAX_DATA-1:0] data_q,
   output logic                perr_q,
   output logic                brk_q
);
   localparam int CW   = $clog2(OVS);
   localparam int HALF = OVS / 2;

   typedef enum logic [1:0] {S_IDLE, S_ACT, S_HOLD} rx_st_e;

   rx_st_e              st;
   logic [CW-1:0]       tcnt;
   logic [3:0]          idx, stop_pos;
   logic [MAX_DATA-1:0] sh;
   logic                pacc, allz, samp;

   assign stop_pos = fmt.nbits + 4'd1 + {3'b0, fmt.par_en};
   assign samp     = (st == S_ACT) && tick && (tcnt == CW'(HALF - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st <= S_IDLE; tcnt <= '0; idx <= '0; sh <= '0;
         pacc <= 1'b0; allz <= 1'b1; valid <= 1'b0;
         data_q <= '0; perr_q <= 1'b0; brk_q <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (!en) begin
            st    <= S_IDLE;
            brk_q <= 1'b0;
         end else begin
            case (st)
               S_IDLE: if (!rxd) begin
                  st <= S_ACT; tcnt <= '0; idx <= '0;
                  sh <= '0; pacc <= 1'b0; allz <= 1'b1;
               end
               S_ACT: begin
                  if (tick) tcnt <= tcnt + 1'b1;
                  if (samp) begin
                     if (idx == 4'd0) begin
                        if (rxd) st <= S_IDLE;
                        else     idx <= 4'd1;
                     end else if (idx == stop_pos) begin
                        if (rxd) begin
                           valid  <= 1'b1;
                           data_q <= sh;
                           perr_q <= fmt.par_en && (pacc != fmt.par_odd);
                           st     <= S_IDLE;
                        end else begin
                           if (allz) brk_q <= 1'b1;
                           st <= S_HOLD;
                        end
                     end else begin
                        for (int i = 0; i < MAX_DATA; i++)
                           if (idx == 4'(i + 1) && idx <= fmt.nbits) sh[i] <= rxd;
                        pacc <= pacc ^ rxd;
                        allz <= allz & ~rxd;
                        idx  <= idx + 4'd1;
                     end
                  end
               end
               default: if (rxd) begin
                  brk_q <= 1'b0;
                  st    <= S_IDLE;
               end
            endcase
         end
      end
   end
endmodule

// File: rtl/usart_core.sv
module usart_core
   import usart_pkg::*;
#(
   parameter int OVS         = 16,
   parameter int SYNC_STAGES = 2,
   parameter int AW          = 3,
   parameter int DW          = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          baud_tick,
   input  logic [AW-1:0] reg_addr,
   input  logic          reg_wr,
   input  logic          reg_rd,
   input  logic [DW-1:0] reg_wdata,
   output logic [DW-1:0] reg_rdata,
   input  logic          ser_rx,
   output logic          ser_tx,
   input  logic          cts_in,
   output logic          irq
);
   localparam logic [DW-1:0] CFG_MASK = DW'(16'h027D);

   if (OVS < 4 || (OVS & (OVS - 1)) != 0) begin : g_bad_ovs
      $error("OVS must be a power of two of at least 4");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("SYNC_STAGES must be at least 2");
   end
   if (DW < 16 || AW < 3) begin : g_bad_bus
      $error("register bus must be at least 16 data and 3 address bits");
   end

   logic [DW-1:0]       cfg_q;
   logic                brk_q, ie_rx_q, ie_tx_q;
   logic [MAX_DATA-1:0] hold_q;
   logic                hold_full_q, rx_rdy_q, dcts_q, dbrk_q, cts_prev, brk_prev;
   logic                rx_s, cts_s, tx_load, rx_valid, rx_perr, rx_brk;
   logic [MAX_DATA-1:0] rx_data;
   frame_cfg_t          fmt;
   logic                wr_cfg, wr_ctrl, wr_stat, wr_ieset, wr_ieclr, wr_txd, rd_rxd;

   assign fmt      = fmt_decode(cfg_q[15:0]);
   assign wr_cfg   = reg_wr && reg_addr == AW'(A_CFG);
   assign wr_ctrl  = reg_wr && reg_addr == AW'(A_CTRL);
   assign wr_stat  = reg_wr && reg_addr == AW'(A_STAT);
   assign wr_ieset = reg_wr && reg_addr == AW'(A_IESET);
   assign wr_ieclr = reg_wr && reg_addr == AW'(A_IECLR);
   assign wr_txd   = reg_wr && reg_addr == AW'(A_TXD);
   assign rd_rxd   = reg_rd && reg_addr == AW'(A_RXD);

   usart_sync #(.STAGES(SYNC_STAGES), .W(2), .RST_VAL(2'b01)) u_sync (
      .clk(clk), .rst_n(rst_n), .d({cts_in, ser_rx}), .q({cts_s, rx_s}));

   usart_tx #(.OVS(OVS)) u_tx (
      .clk(clk), .rst_n(rst_n), .en(cfg_q[0]), .tick(baud_tick), .fmt(fmt),
      .brk(brk_q), .cts_ok(!cfg_q[9] || cts_s), .load_req(hold_full_q),
      .data(hold_q), .load(tx_load), .txd(ser_tx));

   usart_rx #(.OVS(OVS)) u_rx (
      .clk(clk), .rst_n(rst_n), .en(cfg_q[0]), .tick(baud_tick), .fmt(fmt),
      .rxd(rx_s), .valid(rx_valid), .data_q(rx_data), .perr_q(rx_perr),
      .brk_q(rx_brk));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cfg_q <= '0; brk_q <= 1'b0; ie_rx_q <= 1'b0; ie_tx_q <= 1'b0;
         hold_q <= '0; hold_full_q <= 1'b0; rx_rdy_q <= 1'b0;
         dcts_q <= 1'b0; dbrk_q <= 1'b0; cts_prev <= 1'b0; brk_prev <= 1'b0;
      end else begin
         cts_prev <= cts_s;
         brk_prev <= rx_brk;
         if (wr_cfg)  cfg_q <= reg_wdata & CFG_MASK;
         if (wr_ctrl) brk_q <= reg_wdata[1];
         if (wr_ieset) begin
            ie_rx_q <= ie_rx_q | reg_wdata[0];
            ie_tx_q <= ie_tx_q | reg_wdata[2];
         end else if (wr_ieclr) begin
            ie_rx_q <= ie_rx_q & ~reg_wdata[0];
            ie_tx_q <= ie_tx_q & ~reg_wdata[2];
         end
         if (wr_txd) begin
            hold_q      <= reg_wdata[MAX_DATA-1:0];
            hold_full_q <= 1'b1;
         end else if (tx_load) begin
            hold_full_q <= 1'b0;
         end
         if (rx_valid)    rx_rdy_q <= 1'b1;
         else if (rd_rxd) rx_rdy_q <= 1'b0;
         if (cts_s != cts_prev)                dcts_q <= 1'b1;
         else if (wr_stat && reg_wdata[5])     dcts_q <= 1'b0;
         if (rx_brk != brk_prev)               dbrk_q <= 1'b1;
         else if (wr_stat && reg_wdata[11])    dbrk_q <= 1'b0;
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_addr)
         AW'(A_CFG):   reg_rdata = cfg_q;
         AW'(A_CTRL):  reg_rdata[1] = brk_q;
         AW'(A_STAT): begin
            reg_rdata[0]  = rx_rdy_q;
            reg_rdata[2]  = !hold_full_q;
            reg_rdata[5]  = dcts_q;
            reg_rdata[10] = rx_brk;
            reg_rdata[11] = dbrk_q;
         end
         AW'(A_IESET), AW'(A_IECLR): begin
            reg_rdata[0] = ie_rx_q;
            reg_rdata[2] = ie_tx_q;
         end
         AW'(A_RXD): begin
            reg_rdata[MAX_DATA-1:0] = rx_data;
            reg_rdata[15]           = rx_perr;
         end
         default: ;
      endcase
   end

   assign irq = (ie_rx_q && rx_rdy_q) || (ie_tx_q && !hold_full_q);
endmodule

// File: rtl/usart_core_chk.sv
module usart_core_chk #(
   parameter int AW = 3,
   parameter int DW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic [AW-1:0] reg_addr,
   input logic          reg_wr,
   input logic          reg_rd,
   input logic [DW-1:0] reg_wdata,
   input logic          ser_tx,
   input logic          irq,
   input logic [DW-1:0] cfg_q,
   input logic          brk_q,
   input logic          ie_rx_q,
   input logic          ie_tx_q,
   input logic          rx_rdy_q,
   input logic          hold_full_q,
   input logic          rx_valid,
   input logic          tx_load,
   input logic          cts_s,
   input logic          dcts_q
);
   // R2: a disabled core keeps the line at mark
   p_mark_when_off_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !cfg_q[0] |-> ser_tx);

   // R8: break control drives the line low
   p_brk_low_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cfg_q[0] && brk_q) |-> !ser_tx);

   // R5: no frame starts without clear-to-send when gating is on
   p_cts_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_load && cfg_q[9]) |-> cts_s);

   // R6: reading receive data drops receive-ready
   p_rxread_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_rd && reg_addr == AW'(6) && !rx_valid) |=> !rx_rdy_q);

   // R6: a transmit write leaves transmit-ready low in the next cycle
   p_txwr_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && reg_addr == AW'(5)) |=> hold_full_q);

   // R11: with both enables off there is no request
   p_irq_masked_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!ie_rx_q && !ie_tx_q) |-> !irq);

   // R7: the CTS change flag holds until a one is written to it
   p_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (dcts_q && !(reg_wr && reg_addr == AW'(2) && reg_wdata[5])) |=> dcts_q);
endmodule

bind usart_core usart_core_chk #(.AW(AW), .DW(DW)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
   .reg_rd(reg_rd), .reg_wdata(reg_wdata), .ser_tx(ser_tx), .irq(irq),
   .cfg_q(cfg_q), .brk_q(brk_q), .ie_rx_q(ie_rx_q), .ie_tx_q(ie_tx_q),
   .rx_rdy_q(rx_rdy_q), .hold_full_q(hold_full_q), .rx_valid(rx_valid),
   .tx_load(tx_load), .cts_s(cts_s), .dcts_q(dcts_q));

// File: tb/usart_core_tb_top.sv
`timescale 1ns/1ps
module usart_core_tb_top;
   logic        clk = 1'b0, rst_n = 1'b0, baud_tick = 1'b0;
   logic [2:0]  reg_addr = '0;
   logic        reg_wr = 1'b0, reg_rd = 1'b0;
   logic [15:0] reg_wdata = '0;
   logic [15:0] reg_rdata;
   logic        ser_tx, irq;
   logic        drv_rx = 1'b1, loop_en = 1'b1, cts_in = 1'b0;
   logic        ser_rx;
   int          n_chk = 0, n_fail = 0;
   bit          done = 1'b0;

   assign ser_rx = loop_en ? ser_tx : drv_rx;

   always #10 clk = ~clk;
   always @(posedge clk) baud_tick <= rst_n ? ~baud_tick : 1'b0;

   usart_core dut_i (
      .clk(clk), .rst_n(rst_n), .baud_tick(baud_tick), .reg_addr(reg_addr),
      .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_wdata(reg_wdata),
      .reg_rdata(reg_rdata), .ser_rx(ser_rx), .ser_tx(ser_tx),
      .cts_in(cts_in), .irq(irq));

   task automatic check(input string req, input string what,
                        input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] a, input logic [15:0] d);
      @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk); reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] a, output logic [15:0] d);
      @(negedge clk); reg_addr = a; reg_rd = 1'b1;
      #1 d = reg_rdata;
      @(negedge clk); reg_rd = 1'b0;
   endtask

   function automatic void exp_frame(input logic [15:0] cfg, input logic [8:0] d,
                                     output logic [12:0] f, output int len,
                                     output logic [8:0] dm);
      int  nb;
      int  pos;
      logic p;
      nb  = (cfg[3:2] == 2'd0) ? 7 : (cfg[3:2] == 2'd2) ? 9 : 8;
      f   = '1;
      f[0] = 1'b0;
      p   = cfg[4];
      dm  = '0;
      for (int i = 0; i < nb; i++) begin
         f[1+i] = d[i];
         dm[i]  = d[i];
         p      = p ^ d[i];
      end
      pos = 1 + nb;
      if (cfg[5]) begin f[pos] = p; pos++; end
      len = pos + 1 + int'(cfg[6]);
   endfunction

   task automatic capture(input int len, output logic [12:0] f);
      int w;
      w = 0;
      f = '1;
      while (ser_tx !== 1'b0 && w < 6000) begin @(negedge clk); w++; end
      if (w >= 6000) begin
         check("R3", "start bit never seen", 32'd0, 32'd1);
      end else begin
         repeat (16) @(negedge clk);
         f[0] = ser_tx;
         for (int i = 1; i < len; i++) begin
            repeat (32) @(negedge clk);
            f[i] = ser_tx;
         end
      end
   endtask

   task automatic drive_frame(input logic [12:0] f, input int len);
      for (int i = 0; i < len; i++) begin
         @(negedge clk); drv_rx = f[i];
         repeat (31) @(negedge clk);
      end
      @(negedge clk); drv_rx = 1'b1;
   endtask

   task automatic expect_idle(input int n, input string req);
      logic seen_low;
      seen_low = 1'b0;
      repeat (n) begin @(negedge clk); if (ser_tx !== 1'b1) seen_low = 1'b1; end
      check(req, "line left mark", 32'(seen_low), 32'd0);
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog run did not complete");
      finish_run();
   end

   initial begin
      logic [15:0] r, cfg;
      logic [12:0] ef, gf;
      logic [8:0]  dm, d;
      int          len;
      void'($urandom(32'd2024));

      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // R1 reset state
      check("R1", "ser_tx", 32'(ser_tx), 32'd1);
      check("R1", "irq", 32'(irq), 32'd0);
      rd(3'd0, r); check("R1", "cfg", 32'(r), 32'h0);
      rd(3'd2, r); check("R1", "status", 32'(r), 32'h0004);
      rd(3'd3, r); check("R1", "enables", 32'(r), 32'h0);

      // R2 disabled core holds a written character
      wr(3'd5, 16'h0055);
      expect_idle(600, "R2");
      rd(3'd2, r); check("R2", "tx ready while held", 32'(r), 32'h0000);
      cfg = 16'h0005;
      exp_frame(cfg, 9'h055, ef, len, dm);
      wr(3'd0, cfg);
      capture(len, gf);
      check("R2", "frame after enable", 32'(gf), 32'(ef));
      repeat (40) @(negedge clk);
      rd(3'd6, r); check("R2", "loopback data", 32'(r), 32'h0055);

      // R3 R4 R6 random formats in loopback
      for (int k = 0; k < 20; k++) begin
         cfg = 16'h0001 | 16'(($urandom % 3) << 2) | 16'(($urandom % 4) << 4)
               | 16'(($urandom % 2) << 6);
         d = 9'($urandom);
         exp_frame(cfg, d, ef, len, dm);
         wr(3'd0, cfg);
         wr(3'd5, {7'b0, d});
         capture(len, gf);
         check("R3", $sformatf("frame cfg=%h", cfg), 32'(gf), 32'(ef));
         repeat (40) @(negedge clk);
         rd(3'd2, r); check("R6", "rx ready set", 32'(r[0]), 32'd1);
         rd(3'd6, r); check("R4", "rx data no parity error", 32'(r), 32'(dm));
         rd(3'd2, r); check("R6", "rx ready cleared by read", 32'(r[0]), 32'd0);
      end

      // R4 receiver parity check with a hand-built frame
      loop_en = 1'b0;
      cfg = 16'h0025;            // 8 bits, even parity
      wr(3'd0, cfg);
      exp_frame(cfg, 9'h001, ef, len, dm);
      ef[9] = ~ef[9];            // corrupt parity bit
      drive_frame(ef, len);
      repeat (40) @(negedge clk);
      rd(3'd6, r); check("R4", "bad parity flagged", 32'(r), 32'h8001);
      ef[9] = ~ef[9];
      drive_frame(ef, len);
      repeat (40) @(negedge clk);
      rd(3'd6, r); check("R4", "good parity", 32'(r), 32'h0001);

      // R10 short start pulse rejected
      cfg = 16'h0005;
      wr(3'd0, cfg);
      @(negedge clk); drv_rx = 1'b0;
      repeat (4) @(negedge clk); drv_rx = 1'b1;
      repeat (100) @(negedge clk);
      rd(3'd2, r); check("R10", "glitch gave no char", 32'(r[0]), 32'd0);
      exp_frame(cfg, 9'h0C9, ef, len, dm);
      drive_frame(ef, len);
      repeat (40) @(negedge clk);
      rd(3'd6, r); check("R10", "frame after glitch", 32'(r), 32'h00C9);

      // R9 break detection
      @(negedge clk); drv_rx = 1'b0;
      repeat (32 * 10 + 64) @(negedge clk);
      rd(3'd2, r); check("R9", "break live and changed", 32'(r), 32'h0C04);
      wr(3'd2, 16'h0800);
      rd(3'd2, r); check("R9", "change flag cleared", 32'(r), 32'h0404);
      @(negedge clk); drv_rx = 1'b1;
      repeat (10) @(negedge clk);
      rd(3'd2, r); check("R9", "break ended", 32'(r), 32'h0804);
      wr(3'd2, 16'h0800);
      rd(3'd2, r); check("R9", "all clear", 32'(r), 32'h0004);

      // R8 transmit break
      wr(3'd1, 16'h0002);
      @(negedge clk); check("R8", "line forced low", 32'(ser_tx), 32'd0);
      wr(3'd1, 16'h0000);
      @(negedge clk); check("R8", "line released", 32'(ser_tx), 32'd1);

      // R5 R7 clear-to-send gating and change flag
      loop_en = 1'b1;
      cfg = 16'h0205;
      wr(3'd0, cfg);
      wr(3'd5, 16'h00A3);
      expect_idle(400, "R5");
      rd(3'd2, r); check("R5", "held by cts", 32'(r), 32'h0000);
      exp_frame(cfg, 9'h0A3, ef, len, dm);
      @(negedge clk); cts_in = 1'b1;
      capture(len, gf);
      check("R5", "frame after cts", 32'(gf), 32'(ef));
      repeat (40) @(negedge clk);
      rd(3'd2, r); check("R7", "cts change seen", 32'(r), 32'h0025);
      wr(3'd2, 16'h0020);
      rd(3'd2, r); check("R7", "cts change cleared", 32'(r), 32'h0005);
      rd(3'd6, r); check("R5", "loopback data", 32'(r), 32'h00A3);

      // R11 interrupt enables
      wr(3'd3, 16'h0001);
      check("R11", "rx enable alone", 32'(irq), 32'd0);
      wr(3'd3, 16'h0004);
      check("R11", "tx ready enabled", 32'(irq), 32'd1);
      rd(3'd3, r); check("R11", "enable readback", 32'(r), 32'h0005);
      wr(3'd4, 16'h0004);
      check("R11", "tx enable cleared", 32'(irq), 32'd0);
      exp_frame(cfg, 9'h03C, ef, len, dm);
      wr(3'd5, 16'h003C);
      capture(len, gf);
      repeat (40) @(negedge clk);
      check("R11", "rx ready request", 32'(irq), 32'd1);
      rd(3'd6, r); check("R11", "data", 32'(r), 32'h003C);
      check("R11", "request dropped after read", 32'(irq), 32'd0);
      wr(3'd4, 16'h0001);

      finish_run();
   end
endmodule